// File: doc/BRIEF.md
# Dual-Modulus Loop Divider with Reference Divider

This block is the digital part of a frequency synthesizer's feedback divider. It runs on the output of an external two-modulus prescaler and drives that prescaler's modulus-control line. For the first A prescaler output pulses of each cycle it asks for the M+1 ratio. For the remaining N-A pulses it asks for M. The VCO is therefore divided by M*N + A in total. At the end of every cycle the block emits a one-clock comparison strobe. The prescaler's base modulus (32 or 64) is also chosen at run time through a select bit, which the block registers and passes to the prescaler.

A second counter runs on the oscillator clock. It divides that clock by R and emits the reference comparison strobe. Both counters pick up new N, A, R and modulus values only when they wrap, so a cycle already in progress is never shortened or stretched. A power-save input clears and holds both counters. On release, both counters start from zero on their first clock edge, which keeps the two strobes in a known phase relation.

Top module: `psw_divider_ctrl`

## Requirements
- R1: `fp_strobe` is high for exactly one `pre_clk` cycle. It repeats every N `pre_clk` cycles, where N is the loaded main ratio (legal range 5 to 2047).
- R2: `mod_ctrl` is high (1 = ask for M+1) during the first A `pre_clk` cycles of each divider cycle, counting the cycle in which `fp_strobe` is high as the first. It is low for the remaining N-A cycles. With A = 0 it never goes high. A must be less than N (swallow range 0 to 127).
- R3: `fr_strobe` is high for exactly one `osc_clk` cycle. It repeats every R `osc_clk` cycles (legal range 5 to 16383).
- R4: `mode32_o` carries the loaded modulus select (1 = 32/33, 0 = 64/65). It changes only in the cycle in which `fp_strobe` is high.
- R5: A change of `n_div`, `a_swl` or `mode32_sel` during a cycle does not alter that cycle. The new value governs the cycle that starts at the next `fp_strobe`.
- R6: A change of `r_div` during a reference period does not alter that period. The new value governs the period that starts at the next `fr_strobe`.
- R7: While `pwr_save` is 1, both strobes stay low. After release, the first `fp_strobe` appears on the N-th `pre_clk` rising edge and the first `fr_strobe` on the R-th `osc_clk` rising edge.
- R8: While `rst_n` is low, both strobes are low. `mode32_o` follows `mode32_sel`, and `mod_ctrl` is 1 exactly when `a_swl` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pre_clk | input | 1 | Prescaler output clock |
| osc_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| pwr_save | input | 1 | 1 = clear and hold both counters |
| n_div | input | 11 | Main counter ratio N |
| a_swl | input | 7 | Swallow count A |
| r_div | input | 14 | Reference ratio R |
| mode32_sel | input | 1 | Modulus select: 1 = 32/33, 0 = 64/65 |
| mod_ctrl | output | 1 | Prescaler modulus control, 1 = M+1 |
| mode32_o | output | 1 | Registered modulus select sent to the prescaler |
| fp_strobe | output | 1 | Divided comparison strobe, `pre_clk` domain |
| fr_strobe | output | 1 | Reference comparison strobe, `osc_clk` domain |

## Verification
The bench runs the smallest legal ratio with the largest swallow count (N = 5, A = 4), a zero swallow count and a mid-range pair. A swallow counter off by one would show one extra or one missing M+1 pulse, and an N-1 or N+1 period would show as a wrong strobe spacing. It changes ratios and the modulus select in the middle of a cycle. A design that loaded them immediately would give an intermediate period of the wrong length, or move `mode32_o` before the strobe. It also releases power save and counts edges to each first strobe. A counter that did not restart from zero, or that counted the release edge twice, would land one or more edges off.

// File: rtl/psw_pkg.sv
// Shared defaults for the dual-modulus divider controller.
// Assumes: widths follow the legal ratio ranges (N up to 2047, A up to 127,
// R up to 16383); ratios below MIN_RATIO are not supported.
package psw_pkg;
    localparam int N_W_DEF   = 11;
    localparam int A_W_DEF   = 7;
    localparam int R_W_DEF   = 14;
    localparam int MIN_RATIO = 5;

    // Encoding of the modulus select bit as driven to the prescaler.
    typedef enum logic {
        PSC_64_65 = 1'b0,
        PSC_32_33 = 1'b1
    } psc_mode_e;
endpackage

// File: rtl/psw_reload_reg.sv
// Shadow register for a divider setting.
// While reset or power save is active it follows its input, so a counter that
// restarts uses the current setting. Otherwise it captures the input only on a
// load pulse, which is the counter wrap.
// Assumes: d is quasi-static with respect to clk.
module psw_reload_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         track,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the setting on reset/track or at the wrap point.
    always_ff @(posedge clk) begin
        if (!rst_n || track) begin
            q <= d;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/psw_main_div.sv
// Pulse-swallow main divider in the prescaler-output clock domain.
// A swallow counter holds the modulus-control line high for the first A clocks
// of each cycle. A main counter spans N clocks and wraps, and on the wrap it
// reloads N, A and the modulus select and issues a one-clock strobe.
// Assumes: 5 <= N, A < N, settings stable around the wrap edge.
module psw_main_div #(
    parameter int N_W = psw_pkg::N_W_DEF,
    parameter int A_W = psw_pkg::A_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_save,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    input  logic           sel_in,
    output logic           mod_ctrl,
    output logic           sel_o,
    output logic           strobe
);
    localparam int CFG_W = N_W + A_W + 1;
    localparam logic [N_W-1:0] N_ONE = N_W'(1);
    localparam logic [N_W-1:0] N_ZERO = '0;
    localparam logic [A_W-1:0] A_ONE = A_W'(1);
    localparam logic [A_W-1:0] A_ZERO = '0;

    logic [CFG_W-1:0] cfg_q;
    logic [N_W-1:0]   n_act;
    logic [A_W-1:0]   a_act;
    logic [N_W-1:0]   mn_cnt;
    logic [A_W-1:0]   sw_cnt;
    logic             wrap;
    logic             hold;

    assign hold = pwr_save;

    psw_reload_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .track (hold),
        .load  (wrap),
        .d     ({n_in, a_in, sel_in}),
        .q     (cfg_q)
    );

    // Split the shadow into its fields.
    always_comb begin
        n_act = cfg_q[CFG_W-1 -: N_W];
        a_act = cfg_q[A_W:1];
        sel_o = cfg_q[0];
    end

    // Last clock of the cycle.
    always_comb begin
        wrap = (mn_cnt == (n_act - N_ONE));
    end

    // Main counter: position of the current clock inside the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            mn_cnt <= N_ZERO;
        end else if (wrap) begin
            mn_cnt <= N_ZERO;
        end else begin
            mn_cnt <= mn_cnt + N_ONE;
        end
    end

    // Swallow counter: advances until it meets A, restarts with the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            sw_cnt <= A_ZERO;
        end else if (wrap) begin
            sw_cnt <= A_ZERO;
        end else if (sw_cnt != a_act) begin
            sw_cnt <= sw_cnt + A_ONE;
        end
    end

    // Modulus control: M+1 while swallowed pulses remain.
    always_comb begin
        mod_ctrl = (sw_cnt != a_act);
    end

    // Comparison strobe, high in the first clock of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            strobe <= 1'b0;
        end else begin
            strobe <= wrap;
        end
    end
endmodule

// File: rtl/psw_ref_div.sv
// Programmable reference divider in the oscillator clock domain.
// It counts R clocks, then wraps, reloads R and issues a one-clock strobe.
// Assumes: 5 <= R, setting stable around the wrap edge.
module psw_ref_div #(
    parameter int R_W = psw_pkg::R_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_save,
    input  logic [R_W-1:0] r_in,
    output logic           strobe
);
    localparam logic [R_W-1:0] R_ONE = R_W'(1);
    localparam logic [R_W-1:0] R_ZERO = '0;

    logic [R_W-1:0] r_act;
    logic [R_W-1:0] rf_cnt;
    logic           wrap;

    psw_reload_reg #(.W(R_W)) u_rcfg (
        .clk   (clk),
        .rst_n (rst_n),
        .track (pwr_save),
        .load  (wrap),
        .d     (r_in),
        .q     (r_act)
    );

    // Last clock of the reference period.
    always_comb begin
        wrap = (rf_cnt == (r_act - R_ONE));
    end

    // Reference counter.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save) begin
            rf_cnt <= R_ZERO;
        end else if (wrap) begin
            rf_cnt <= R_ZERO;
        end else begin
            rf_cnt <= rf_cnt + R_ONE;
        end
    end

    // Reference strobe, high in the first clock of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save) begin
            strobe <= 1'b0;
        end else begin
            strobe <= wrap;
        end
    end
endmodule

// File: rtl/psw_divider_ctrl.sv
// Top of the dual-modulus divider controller.
// It joins the pulse-swallow main divider (prescaler clock) and the reference
// divider (oscillator clock). Power save clears both so they restart together.
// Assumes: rst_n and pwr_save are held long enough to be seen by both clocks
// and change away from either clock edge. No synchronizer sits on them, so the
// restart is exact on each domain's first edge.
module psw_divider_ctrl #(
    parameter int N_W = psw_pkg::N_W_DEF,
    parameter int A_W = psw_pkg::A_W_DEF,
    parameter int R_W = psw_pkg::R_W_DEF
) (
    input  logic           pre_clk,
    input  logic           osc_clk,
    input  logic           rst_n,
    input  logic           pwr_save,
    input  logic [N_W-1:0] n_div,
    input  logic [A_W-1:0] a_swl,
    input  logic [R_W-1:0] r_div,
    input  logic           mode32_sel,
    output logic           mod_ctrl,
    output logic           mode32_o,
    output logic           fp_strobe,
    output logic           fr_strobe
);
    psw_main_div #(.N_W(N_W), .A_W(A_W)) u_main (
        .clk      (pre_clk),
        .rst_n    (rst_n),
        .pwr_save (pwr_save),
        .n_in     (n_div),
        .a_in     (a_swl),
        .sel_in   (mode32_sel),
        .mod_ctrl (mod_ctrl),
        .sel_o    (mode32_o),
        .strobe   (fp_strobe)
    );

    psw_ref_div #(.R_W(R_W)) u_ref (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .pwr_save (pwr_save),
        .r_in     (r_div),
        .strobe   (fr_strobe)
    );
endmodule

// File: rtl/psw_divider_chk.sv
// Property checker for psw_divider_ctrl, bound to every instance of the top.
module psw_divider_chk #(
    parameter int N_W = psw_pkg::N_W_DEF,
    parameter int A_W = psw_pkg::A_W_DEF,
    parameter int R_W = psw_pkg::R_W_DEF
) (
    input logic           pre_clk,
    input logic           osc_clk,
    input logic           rst_n,
    input logic           pwr_save,
    input logic [N_W-1:0] n_div,
    input logic [A_W-1:0] a_swl,
    input logic [R_W-1:0] r_div,
    input logic           mode32_sel,
    input logic           mod_ctrl,
    input logic           mode32_o,
    input logic           fp_strobe,
    input logic           fr_strobe
);
    // R1
    fp_single_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
        fp_strobe |=> !fp_strobe);

    // R3
    fr_single_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        fr_strobe |=> !fr_strobe);

    // R2
    mod_rise_chk: assert property (@(posedge pre_clk) disable iff (!rst_n || pwr_save)
        $rose(mod_ctrl) |-> fp_strobe);

    // R4
    mode_hold_chk: assert property (@(posedge pre_clk) disable iff (!rst_n || pwr_save)
        !$stable(mode32_o) |-> fp_strobe);

    // R7
    ps_main_quiet_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
        pwr_save |=> !fp_strobe);

    // R7
    ps_ref_quiet_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        pwr_save |=> !fr_strobe);
endmodule

bind psw_divider_ctrl psw_divider_chk #(.N_W(N_W), .A_W(A_W), .R_W(R_W)) i_chk (.*);

// File: tb/test_psw_divider_ctrl.sv
module test_psw_divider_ctrl;
    logic        pre_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_save = 1'b0;
    logic [10:0] n_div = 11'd8;
    logic [6:0]  a_swl = 7'd3;
    logic [13:0] r_div = 14'd7;
    logic        mode32_sel = 1'b1;
    logic        mod_ctrl;
    logic        mode32_o;
    logic        fp_strobe;
    logic        fr_strobe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // 250 MHz prescaler clock, oscillator clock at half that rate.
    always #2 pre_clk = ~pre_clk;
    always #4 osc_clk = ~osc_clk;

    psw_divider_ctrl i_psw_divider_ctrl (
        .pre_clk    (pre_clk),
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .pwr_save   (pwr_save),
        .n_div      (n_div),
        .a_swl      (a_swl),
        .r_div      (r_div),
        .mode32_sel (mode32_sel),
        .mod_ctrl   (mod_ctrl),
        .mode32_o   (mode32_o),
        .fp_strobe  (fp_strobe),
        .fr_strobe  (fr_strobe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pstep();
        @(posedge pre_clk);
        #1;
    endtask

    task automatic ostep();
        @(posedge osc_clk);
        #1;
    endtask

    // Steps until fp_strobe is seen; returns the number of steps taken.
    task automatic to_fp(output int n);
        n = 0;
        do begin
            pstep();
            n++;
        end while (fp_strobe !== 1'b1 && n < 5000);
    endtask

    task automatic to_fr(output int n);
        n = 0;
        do begin
            ostep();
            n++;
        end while (fr_strobe !== 1'b1 && n < 20000);
    endtask

    // R8: values while reset is held.
    task automatic t_reset();
        int bad = 0;
        rst_n = 1'b0;
        a_swl = 7'd3;
        mode32_sel = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pstep();
            if (fp_strobe !== 1'b0 || fr_strobe !== 1'b0) bad++;
        end
        chk("R8 strobes low in reset", bad, 0);
        chk("R8 mod_ctrl with A=3", int'(mod_ctrl), 1);
        chk("R8 mode32_o follows select", int'(mode32_o), 1);
        a_swl = 7'd0;
        mode32_sel = 1'b0;
        pstep();
        pstep();
        chk("R8 mod_ctrl with A=0", int'(mod_ctrl), 0);
        chk("R8 mode32_o follows select 0", int'(mode32_o), 0);
        rst_n = 1'b1;
    endtask

    // R1, R2: one full cycle with new N and A.
    task automatic t_cycle(input int nv, input int av);
        int dummy;
        int mod_bad = 0;
        int stb_cnt = 0;
        int mod_hi = 0;
        n_div = 11'(nv);
        a_swl = 7'(av);
        to_fp(dummy);
        to_fp(dummy);
        for (int k = 0; k < nv; k++) begin
            if (int'(mod_ctrl) != ((k < av) ? 1 : 0)) mod_bad++;
            if (mod_ctrl === 1'b1) mod_hi++;
            if (fp_strobe === 1'b1) stb_cnt++;
            pstep();
        end
        chk($sformatf("R2 mod_ctrl pattern N=%0d A=%0d", nv, av), mod_bad, 0);
        chk($sformatf("R2 M+1 clocks N=%0d A=%0d", nv, av), mod_hi, av);
        chk($sformatf("R1 one strobe per cycle N=%0d", nv), stb_cnt, 1);
        chk($sformatf("R1 strobe after N=%0d clocks", nv), int'(fp_strobe), 1);
    endtask

    // R5: N changed mid-cycle keeps the current cycle.
    task automatic t_n_change(input int n_old, input int n_new);
        int n;
        n_div = 11'(n_old);
        to_fp(n);
        to_fp(n);
        pstep();
        pstep();
        n_div = 11'(n_new);
        to_fp(n);
        chk("R5 cycle in progress keeps old N", n, n_old - 2);
        to_fp(n);
        chk("R5 next cycle uses new N", n, n_new);
    endtask

    // R4, R5: modulus select switches only at the strobe.
    task automatic t_mode();
        int n;
        int early = 0;
        to_fp(n);
        pstep();
        mode32_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pstep();
            if (mode32_o !== 1'b0) early++;
        end
        chk("R4 mode32_o held until reload", early, 0);
        to_fp(n);
        chk("R4 mode32_o updated at strobe", int'(mode32_o), 1);
        mode32_sel = 1'b0;
        to_fp(n);
        chk("R4 mode32_o back to 64/65", int'(mode32_o), 0);
    endtask

    // R3: reference period.
    task automatic t_ref(input int rv);
        int n;
        r_div = 14'(rv);
        to_fr(n);
        to_fr(n);
        ostep();
        chk($sformatf("R3 fr_strobe single cycle R=%0d", rv), int'(fr_strobe), 0);
        to_fr(n);
        chk($sformatf("R3 reference period R=%0d", rv), n, rv - 1);
    endtask

    // R6: R changed mid-period.
    task automatic t_r_change(input int r_old, input int r_new);
        int n;
        r_div = 14'(r_old);
        to_fr(n);
        to_fr(n);
        ostep();
        r_div = 14'(r_new);
        to_fr(n);
        chk("R6 period in progress keeps old R", n, r_old - 1);
        to_fr(n);
        chk("R6 next period uses new R", n, r_new);
    endtask

    // R7: power save quiets strobes and restarts both counters from zero.
    task automatic t_psave(input int nv, input int rv);
        int bad = 0;
        int nfp = 0;
        int nfr = 0;
        n_div = 11'(nv);
        r_div = 14'(rv);
        pstep();
        pwr_save = 1'b1;
        pstep();
        for (int i = 0; i < 20; i++) begin
            pstep();
            if (fp_strobe !== 1'b0 || fr_strobe !== 1'b0) bad++;
        end
        chk("R7 strobes low in power save", bad, 0);
        pwr_save = 1'b0;
        fork
            to_fp(nfp);
            to_fr(nfr);
        join
        chk("R7 first fp_strobe after release", nfp, nv);
        chk("R7 first fr_strobe after release", nfr, rv);
    endtask

    initial begin
        t_reset();
        pstep();
        t_cycle(8, 3);
        t_cycle(5, 4);
        t_cycle(9, 0);
        t_cycle(40, 17);
        t_n_change(12, 6);
        t_mode();
        t_ref(7);
        t_ref(5);
        t_r_change(9, 14);
        t_psave(10, 6);
        t_cycle(10, 6);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge pre_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule